// File: doc/BRIEF.md
# DRAM Strobe Sequencer with Refresh Scheduling

This block sits between a simple host port and a DRAM whose address pins are shared between the row and the column. A host raises a request with a 12-bit word address, a write flag and one data bit. The controller splits the address into a 6-bit row and a 6-bit column and drives them over one 6-bit bus. It then produces the row strobe, column strobe and write-enable waveforms. When the access is complete it pulses a one-cycle ready signal. For reads, the data bit is valid on `rd_data` in that cycle.

After an access the row is left open. A later access to the same row reuses it with only a new column address and a new column strobe pulse. An access to a different row first closes the page and waits out a precharge interval. A down-counter raises a refresh request at a fixed interval, so every one of the 64 rows is refreshed within 4 ms. The refresh is done in one of two ways, chosen by `ref_mode`. In the first, the controller drives its own row pointer on the bus and strobes only the row line. In the second, the column strobe is lowered before the row strobe and the device keeps the row count itself.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is held and after its release with no traffic, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1 and `req_ready` is 0.
- R2: For an access, `dram_addr` carries `req_addr[11:6]` when `dram_ras_n` falls and `req_addr[5:0]` when `dram_cas_n` falls.
- R3: For a write, `dram_we_n` is 0 and `dram_wdata` equals the request bit before `dram_cas_n` falls, and `dram_we_n` does not change while `dram_cas_n` is low. For a read, `dram_we_n` stays 1.
- R4: Read data is sampled from `dram_rdata` on the last cycle of the column-strobe-low phase. `req_ready` is then high for exactly one cycle, with `rd_data` valid in that cycle.
- R5: An access whose row equals the open row produces no new falling edge of `dram_ras_n`, only a new column address and a new `dram_cas_n` pulse.
- R6: An access to a different row raises `dram_ras_n`, precharges, and opens the new row with a fresh falling edge.
- R7: Between any two low periods, `dram_ras_n` stays high for at least `T_PRE` cycles.
- R8: A refresh is requested every `REF_CYCLES` clock cycles (default 3125, i.e. 62.5 µs at 50 MHz). Consecutive refreshes are never further apart than `REF_CYCLES` plus the length of one access and one precharge.
- R9: A pending refresh starts before any waiting host request. It never cuts short a cycle already in progress, and it closes an open page first.
- R10: With `ref_mode`=0, a refresh lowers `dram_ras_n` with `dram_cas_n` held high throughout. The bus carries an internal row pointer that starts at 0 and advances by one (mod 64) per refresh.
- R11: With `ref_mode`=1, `dram_cas_n` falls before `dram_ras_n`, `dram_addr` is all zeros, and the internal row pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_mode | input | 1 | Refresh method: 0 row-strobe-only with internal pointer, 1 column-before-row |
| req_valid | input | 1 | Host request, held until `req_ready` |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Word address: bits 11:6 row, bits 5:0 column |
| req_wdata | input | 1 | Write data bit |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 1 | Read data, valid with `req_ready` |
| dram_addr | output | 6 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | 1 | Data to the device |
| dram_rdata | input | 1 | Data from the device |

## Verification
The collision that matters is a refresh request maturing while a host stream keeps a page open, or while a new request waits in the idle state. The bench provokes it with a long back-to-back stream of accesses to one row, running over several refresh periods. A behavioural device model on the strobes then judges several things: each refresh still lands within its interval bound, every refresh is preceded by a full precharge, the row-pointer sequence stays unbroken, and every read returned after the interruption matches the scoreboard.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_OPEN,
        ST_RFR,
        ST_CBR_C,
        ST_CBR_R
    } dram_st_e;

    localparam logic MODE_ROWONLY = 1'b0;
    localparam logic MODE_CBR     = 1'b1;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int REF_CYCLES = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int TW = $clog2(REF_CYCLES + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (ack) d.pend = 1'b0;
        if (q.cnt == '0) begin
            d.cnt  = TW'(REF_CYCLES - 1);
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt  <= TW'(REF_CYCLES - 1);
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pend = q.pend;

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !ack) |=> q.pend);
endmodule

// File: rtl/dram_ref_row.sv
module dram_ref_row #(
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (adv) row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    // R10
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int REF_CYCLES = 3125,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_PRE      = 3,
    parameter int T_RFR      = 3,
    parameter int T_CBR      = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_mode,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_wdata,
    output logic                req_ready,
    output logic                rd_data,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_wdata,
    input  logic                dram_rdata
);
    localparam int ROW_W = ADDR_W / 2;
    localparam int COL_W = ADDR_W - ROW_W;
    localparam int T_A   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_B   = (T_PRE > T_RFR) ? T_PRE : T_RFR;
    localparam int T_C   = (T_A > T_B) ? T_A : T_B;
    localparam int T_MAX = (T_C > T_CBR) ? T_C : T_CBR;
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        dram_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [ROW_W-1:0]  addr;
        logic              dout;
        logic              rdata;
        logic              ready;
        logic [ROW_W-1:0]  open_row;
        logic [ADDR_W-1:0] cur_addr;
        logic              cur_wr;
        logic              cur_wd;
    } ctl_t;

    ctl_t d, q;
    logic             ref_pend, ref_ack, row_adv, req_go, cnt_done;
    logic [ROW_W-1:0] ref_row, req_row;

    dram_ref_timer #(.REF_CYCLES(REF_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
    );

    dram_ref_row #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(ref_row)
    );

    assign req_go   = req_valid && !q.ready;
    assign req_row  = req_addr[ADDR_W-1 -: ROW_W];
    assign cnt_done = (q.cnt == '0);

    always_comb begin
        d       = q;
        d.ready = 1'b0;
        ref_ack = 1'b0;
        row_adv = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.ras_n = 1'b1;
                d.cas_n = 1'b1;
                d.we_n  = 1'b1;
                if (ref_pend) begin
                    ref_ack = 1'b1;
                    if (ref_mode == MODE_CBR) begin
                        d.st    = ST_CBR_C;
                        d.cas_n = 1'b0;
                        d.addr  = '0;
                        d.cnt   = CNT_W'(T_CBR - 1);
                    end else begin
                        d.st    = ST_RFR;
                        d.ras_n = 1'b0;
                        d.addr  = ref_row;
                        d.cnt   = CNT_W'(T_RFR - 1);
                    end
                end else if (req_go) begin
                    d.st       = ST_ROW;
                    d.ras_n    = 1'b0;
                    d.addr     = req_row;
                    d.cnt      = CNT_W'(T_RCD - 1);
                    d.cur_addr = req_addr;
                    d.cur_wr   = req_write;
                    d.cur_wd   = req_wdata;
                end
            end
            ST_ROW: begin
                if (cnt_done) begin
                    d.st   = ST_COL;
                    d.addr = q.cur_addr[COL_W-1:0];
                    d.we_n = !q.cur_wr;
                    d.dout = q.cur_wd;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                d.st    = ST_CAS;
                d.cas_n = 1'b0;
                d.cnt   = CNT_W'(T_CAS - 1);
            end
            ST_CAS: begin
                if (cnt_done) begin
                    if (!q.cur_wr) d.rdata = dram_rdata;
                    d.ready    = 1'b1;
                    d.cas_n    = 1'b1;
                    d.we_n     = 1'b1;
                    d.open_row = q.cur_addr[ADDR_W-1 -: ROW_W];
                    d.st       = ST_OPEN;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_OPEN: begin
                if (ref_pend || (req_go && req_row != q.open_row)) begin
                    d.st    = ST_PRE;
                    d.ras_n = 1'b1;
                    d.cnt   = CNT_W'(T_PRE - 1);
                end else if (req_go) begin
                    d.st       = ST_COL;
                    d.addr     = req_addr[COL_W-1:0];
                    d.we_n     = !req_write;
                    d.dout     = req_wdata;
                    d.cur_addr = req_addr;
                    d.cur_wr   = req_write;
                    d.cur_wd   = req_wdata;
                end
            end
            ST_PRE: begin
                if (cnt_done) d.st  = ST_IDLE;
                else          d.cnt = q.cnt - 1'b1;
            end
            ST_RFR: begin
                if (cnt_done) begin
                    d.ras_n = 1'b1;
                    d.st    = ST_PRE;
                    d.cnt   = CNT_W'(T_PRE - 1);
                    row_adv = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CBR_C: begin
                if (cnt_done) begin
                    d.ras_n = 1'b0;
                    d.st    = ST_CBR_R;
                    d.cnt   = CNT_W'(T_RFR - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CBR_R: begin
                if (cnt_done) begin
                    d.ras_n = 1'b1;
                    d.cas_n = 1'b1;
                    d.st    = ST_PRE;
                    d.cnt   = CNT_W'(T_PRE - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = q.ready;
    assign rd_data    = q.rdata;
    assign dram_addr  = q.addr;
    assign dram_ras_n = q.ras_n;
    assign dram_cas_n = q.cas_n;
    assign dram_we_n  = q.we_n;
    assign dram_wdata = q.dout;

    // Count of consecutive row-strobe-high cycles; reset counts as precharged.
    logic [CNT_W-1:0] hi_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            hi_cnt_q <= CNT_W'(T_PRE);
        else if (!q.ras_n)     hi_cnt_q <= '0;
        else if (hi_cnt_q < CNT_W'(T_PRE)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    // R7
    precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ras_n) |-> (hi_cnt_q >= CNT_W'(T_PRE)));

    // R4
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ready |=> !q.ready);

    // R3
    we_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cas_n && !$past(q.cas_n)) |-> $stable(q.we_n));

    // R11
    cbr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.ras_n) && !q.cas_n) |-> (q.addr == '0));

    // R9
    ref_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && ref_pend) |=> (q.st == ST_RFR || q.st == ST_CBR_C));
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
    localparam int REF   = 400;
    localparam int TPRE  = 3;
    localparam int SLACK = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        req_ready, rd_data;
    logic [5:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_wdata, dram_rdata;

    always #10 clk = ~clk;

    dram_ctrl #(.REF_CYCLES(REF), .T_PRE(TPRE)) uut (
        .clk(clk), .rst_n(rst_n), .ref_mode(ref_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc = cyc + 1;

    // Behavioural device model and strobe observer
    logic       mem [0:4095];
    logic       sh  [0:4095];
    logic [5:0] row_lat = '0, col_lat = '0;
    logic [5:0] exp_row, exp_col, exp_ref_row = '0;
    logic       exp_wr = 1'b0, exp_wd = 1'b0;
    bit         cas_seen = 1'b1, in_cbr = 1'b0;
    int         ras_falls = 0, cbr_cnt = 0, rfr_cnt = 0, ref_total = 0;
    int         last_rise = -1000, last_ref = 0;

    assign dram_rdata = mem[{row_lat, col_lat}];

    task automatic note_ref();
        chk(cyc - last_ref <= REF + SLACK, "R8 refresh gap", cyc - last_ref, REF + SLACK);
        last_ref = cyc;
        ref_total++;
    endtask

    always @(negedge dram_ras_n) if (rst_n) begin
        chk(cyc - last_rise >= TPRE, "R7 precharge", cyc - last_rise, TPRE);
        if (!dram_cas_n) begin
            in_cbr = 1'b1;
            cbr_cnt++;
            chk(dram_addr == 6'd0, "R11 cbr address", dram_addr, 0);
            note_ref();
        end else begin
            row_lat  = dram_addr;
            cas_seen = 1'b0;
            ras_falls++;
        end
    end

    always @(posedge dram_ras_n) if (rst_n) begin
        last_rise = cyc;
        if (in_cbr) in_cbr = 1'b0;
        else if (!cas_seen) begin
            chk(row_lat == exp_ref_row, "R10 refresh row", row_lat, exp_ref_row);
            exp_ref_row = exp_ref_row + 1'b1;
            rfr_cnt++;
            note_ref();
        end
    end

    always @(negedge dram_cas_n) if (rst_n && !dram_ras_n) begin
        cas_seen = 1'b1;
        col_lat  = dram_addr;
        chk(row_lat == exp_row, "R2 row half", row_lat, exp_row);
        chk(dram_addr == exp_col, "R2 column half", dram_addr, exp_col);
        chk(dram_we_n == !exp_wr, "R3 write enable", dram_we_n, !exp_wr);
        if (exp_wr) chk(dram_wdata == exp_wd, "R3 write data", dram_wdata, exp_wd);
        if (!dram_we_n) mem[{row_lat, dram_addr}] = dram_wdata;
    end

    // Scoreboard
    typedef struct packed { bit rd; logic val; logic [11:0] a; } item_t;
    item_t exq[$];
    bit rdy_prev = 1'b0;

    always @(negedge clk) if (rst_n) begin
        if (req_ready) begin
            chk(!rdy_prev, "R4 ready width", 2, 1);
            if (exq.size() == 0) chk(1'b0, "R4 unexpected ready", 1, 0);
            else begin
                item_t it;
                it = exq.pop_front();
                if (it.rd) chk(rd_data == it.val, "R4 read data", rd_data, it.val);
            end
        end
        rdy_prev = req_ready;
    end

    task automatic access(input logic [11:0] a, input logic w, input logic wd);
        item_t it;
        exp_row = a[11:6];
        exp_col = a[5:0];
        exp_wr  = w;
        exp_wd  = wd;
        it.rd = !w; it.val = sh[a]; it.a = a;
        exq.push_back(it);
        if (w) sh[a] = wd;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        do @(negedge clk); while (!req_ready);
        req_valid = 1'b0;
    endtask

    task automatic wait_refs(input int n);
        int base;
        base = ref_total;
        while (ref_total < base + n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin mem[i] = 1'b0; sh[i] = 1'b0; end
    end

    // Watchdog
    initial begin
        while (cyc < 150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f, r0, c0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(!req_ready, "R1 ready in reset", req_ready, 0);
        rst_n = 1'b1;
        last_ref = cyc;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n}, 7);

        // R2 R3 R4: address corners, writes and read-back
        access(12'h000, 1'b1, 1'b1);
        access(12'hFFF, 1'b1, 1'b1);
        access(12'h041, 1'b1, 1'b0);
        access(12'h7C3, 1'b1, 1'b1);
        access(12'h000, 1'b0, 1'b0);
        access(12'hFFF, 1'b0, 1'b0);
        access(12'h041, 1'b0, 1'b0);
        access(12'h7C3, 1'b0, 1'b0);
        access(12'h555, 1'b0, 1'b0);

        // R5 page hit, R6 page miss, just after a refresh
        wait_refs(1);
        f = ras_falls;
        access(12'h145, 1'b1, 1'b1);
        access(12'h14A, 1'b0, 1'b0);
        access(12'h145, 1'b0, 1'b0);
        chk(ras_falls == f + 1, "R5 page hit keeps row open", ras_falls - f, 1);
        access(12'h185, 1'b0, 1'b0);
        chk(ras_falls == f + 2, "R6 page miss reopens", ras_falls - f, 2);

        // R9 R8: refresh interrupting a long same-row stream
        r0 = ref_total;
        for (int i = 0; i < 150; i++) begin
            logic [11:0] a;
            a = {6'd9, 6'($urandom_range(0, 63))};
            access(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        chk(ref_total - r0 >= 2, "R9 refresh cut into open page", ref_total - r0, 2);

        // R11: column-before-row refresh, pointer frozen
        ref_mode = 1'b1;
        wait_refs(1);
        c0 = cbr_cnt; r0 = rfr_cnt;
        wait_refs(2);
        access(12'hABC, 1'b1, 1'b1);
        access(12'hABC, 1'b0, 1'b0);
        chk(cbr_cnt - c0 >= 2, "R11 cbr refreshes", cbr_cnt - c0, 2);
        chk(rfr_cnt == r0, "R11 no row-only refresh", rfr_cnt - r0, 0);

        // R10: back to row-only, pointer continues where it stopped
        ref_mode = 1'b0;
        wait_refs(3);
        chk(rfr_cnt >= r0 + 2, "R10 row-only refreshes resume", rfr_cnt - r0, 2);
        access(12'hABC, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk(exq.size() == 0, "R4 all results returned", exq.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule